// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block drives a two-wire management bus (MDC clock, bidirectional MDIO data) toward one or more PHY devices using extended (Clause 45) framing. Software sees two 32-bit registers on a simple write-strobe bus with a combinational read path. One register holds the 16-bit register address inside the target device. The other carries the port address, the device address, a 3-bit command code and 16 data bits. Writing a valid command to it starts a transaction.

Each transaction is two back-to-back frames on the wire. The first is an address frame that loads the in-device register address. The second is a write frame or a read frame aimed at that address. The block shows busy from the command until the second frame ends. After a read, it returns the received 16 bits together with a valid flag. MDC is divided down from the system clock. The block drives the tristate enable for MDIO and releases the line whenever the PHY owns it.

Top module: `xmdio_master`

## Requirements
- R1: After synchronous reset both registers read as zero, busy (bit 30) and read-valid (bit 29) are 0, and the MDIO output enable is low.
- R2: The command register sits at offset 0x00 and reads back as {0, busy[30], rvalid[29], code[28:26], device[25:21], port[20:16], data[15:0]}. The address register sits at offset 0x08, stores bits 15:0 of a write and reads them back in bits 15:0. Any other offset reads zero.
- R3: A write to offset 0x00 while idle whose code field (bits 28:26) is 3'b101 (write) or 3'b111 (read) makes busy read 1 on the next cycle. Any other code value starts nothing: busy stays 0 and no frame appears.
- R4: Every transaction first sends an address frame. It carries exactly 32 driven ones, start 00, operation 00, the 5-bit port, the 5-bit device, turnaround 10, and the address register value as it stood when the command was accepted.
- R5: For code 3'b101 the second frame has operation 01, turnaround 10 and the command's data bits 15:0.
- R6: For code 3'b111 the second frame has operation 11. The master stops driving MDIO from the first turnaround bit to the end of the frame and samples the line on MDC rising edges. When the frame ends, bits 15:0 hold the received word and read-valid is 1.
- R7: Busy stays 1 without a gap across both frames and returns to 0 only after the second frame has completed.
- R8: A write to offset 0x00 while busy is ignored. No extra frame is sent, and the port and device fields keep the values of the running transaction.
- R9: Read-valid is 0 whenever busy is 1. It clears when a new command is accepted and stays 0 after a write transaction.
- R10: MDC has a period of 2*DIV_HALF system clocks. While driven, MDIO changes only at a falling MDC edge.
- R11: The MDIO output enable is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | OFS_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
A wrong sequencer state shows at the ports within one MDC period. Examples are a missing address frame, a data frame with the wrong operation bits, or busy dropping between frames. Each of these shows up in the frame stream decoded by the bus model, or in the busy bit read back every cycle. A bit counter that is off by one in the shifter either shifts the decoded fields or leaves the master driving during the turnaround. A read then returns a word that differs from the model's register contents on the same transaction. Stale state in the command register shows up as read-valid still set, or as changed port and device fields, one cycle after a command write.

// File: rtl/xmdio_pkg.sv
package xmdio_pkg;

    localparam int FRAME_W  = 64;
    localparam int PRE_W    = 32;
    localparam int TA_POS   = 17;
    localparam int DATA_MSB = 15;

    localparam int BIT_BUSY   = 30;
    localparam int BIT_RVALID = 29;
    localparam int CODE_LSB   = 26;
    localparam int DEV_LSB    = 21;
    localparam int PORT_LSB   = 16;

    localparam logic [2:0] CODE_WR = 3'b101;
    localparam logic [2:0] CODE_RD = 3'b111;

    typedef enum logic [1:0] {
        FOP_ADDR  = 2'b00,
        FOP_WRITE = 2'b01,
        FOP_READ  = 2'b11
    } frame_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ADDR,
        SQ_DATA
    } seq_state_e;

    typedef struct packed {
        logic [2:0]  code;
        logic [4:0]  dev;
        logic [4:0]  port;
        logic [15:0] data;
    } cmd_t;

    function automatic logic [FRAME_W-1:0] make_frame(
        input frame_op_e   op,
        input logic [4:0]  port,
        input logic [4:0]  dev,
        input logic [15:0] data
    );
        return {{PRE_W{1'b1}}, 2'b00, op, port, dev, 2'b10, data};
    endfunction

    function automatic logic code_ok(input logic [2:0] c);
        return (c == CODE_WR) || (c == CODE_RD);
    endfunction

endpackage

// File: rtl/xmdio_clkdiv.sv
module xmdio_clkdiv #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    output logic mdc,
    output logic rise_tk,
    output logic fall_tk
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap    = (cnt_q == CW'(DIV_HALF - 1));
    assign rise_tk = wrap & ~mdc;
    assign fall_tk = wrap & mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/xmdio_shifter.sv
module xmdio_shifter
    import xmdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rise_tk,
    input  logic               fall_tk,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic               rd_mode,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done,
    output logic [15:0]        rdata
);
    localparam int PW = $clog2(FRAME_W);

    logic [FRAME_W-1:0] sreg_q;
    logic [PW-1:0]      pos_q;
    logic               pend_q;
    logic               act_q;
    logic               rd_q;

    assign mdio_o  = act_q & sreg_q[pos_q];
    assign mdio_oe = act_q & ~(rd_q & (pos_q <= PW'(TA_POS)));

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            pos_q  <= '0;
            pend_q <= 1'b0;
            act_q  <= 1'b0;
            rd_q   <= 1'b0;
            done   <= 1'b0;
            rdata  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !pend_q && !act_q) begin
                sreg_q <= frame;
                rd_q   <= rd_mode;
                pend_q <= 1'b1;
            end
            if (fall_tk) begin
                if (pend_q) begin
                    pend_q <= 1'b0;
                    act_q  <= 1'b1;
                    pos_q  <= PW'(FRAME_W - 1);
                end else if (act_q) begin
                    if (pos_q == '0) begin
                        act_q <= 1'b0;
                        done  <= 1'b1;
                    end else begin
                        pos_q <= pos_q - 1'b1;
                    end
                end
            end
            if (rise_tk && act_q && rd_q && (pos_q <= PW'(DATA_MSB))) begin
                rdata[pos_q[3:0]] <= mdio_i;
            end
        end
    end
endmodule

// File: rtl/xmdio_seq.sv
module xmdio_seq
    import xmdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_cmd,
    input  logic               wr_addr,
    input  logic [28:0]        wdata,
    input  logic               sh_done,
    input  logic [15:0]        sh_rdata,
    output logic               busy,
    output logic               rvalid,
    output cmd_t               cmd_q,
    output logic [15:0]        addr_q,
    output logic               sh_start,
    output logic [FRAME_W-1:0] sh_frame,
    output logic               sh_rd
);
    seq_state_e st_q;
    logic       accept;
    logic       is_rd;

    assign accept = wr_cmd && (st_q == SQ_IDLE) && code_ok(wdata[CODE_LSB +: 3]);
    assign is_rd  = (cmd_q.code == CODE_RD);
    assign busy   = (st_q != SQ_IDLE);

    always_comb begin
        if (st_q == SQ_IDLE) begin
            sh_frame = make_frame(FOP_ADDR, wdata[PORT_LSB +: 5],
                                  wdata[DEV_LSB +: 5], addr_q);
        end else begin
            sh_frame = make_frame(is_rd ? FOP_READ : FOP_WRITE,
                                  cmd_q.port, cmd_q.dev, cmd_q.data);
        end
        sh_start = accept || ((st_q == SQ_ADDR) && sh_done);
        sh_rd    = (st_q == SQ_ADDR) && is_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            cmd_q  <= '0;
            addr_q <= '0;
            rvalid <= 1'b0;
        end else begin
            if (wr_addr) begin
                addr_q <= wdata[15:0];
            end
            unique case (st_q)
                SQ_IDLE: begin
                    if (accept) begin
                        cmd_q.code <= wdata[CODE_LSB +: 3];
                        cmd_q.dev  <= wdata[DEV_LSB +: 5];
                        cmd_q.port <= wdata[PORT_LSB +: 5];
                        cmd_q.data <= wdata[15:0];
                        rvalid     <= 1'b0;
                        st_q       <= SQ_ADDR;
                    end
                end
                SQ_ADDR: begin
                    if (sh_done) st_q <= SQ_DATA;
                end
                SQ_DATA: begin
                    if (sh_done) begin
                        st_q <= SQ_IDLE;
                        if (is_rd) begin
                            cmd_q.data <= sh_rdata;
                            rvalid     <= 1'b1;
                        end
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xmdio_master.sv
module xmdio_master
    import xmdio_pkg::*;
#(
    parameter int DIV_HALF = 2,
    parameter int OFS_W    = 4,
    parameter int OFS_CMD  = 0,
    parameter int OFS_ADR  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic               rise_tk, fall_tk;
    logic               sel_cmd, sel_adr;
    logic               busy, rvalid;
    cmd_t               cmd_q;
    logic [15:0]        addr_q;
    logic               sh_start, sh_rd, sh_done;
    logic [FRAME_W-1:0] sh_frame;
    logic [15:0]        sh_rdata;

    assign sel_cmd = (reg_addr == OFS_W'(OFS_CMD));
    assign sel_adr = (reg_addr == OFS_W'(OFS_ADR));

    xmdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
        .clk     (clk),
        .rst     (rst),
        .mdc     (mdc),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk)
    );

    xmdio_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_cmd   (reg_wr && sel_cmd),
        .wr_addr  (reg_wr && sel_adr),
        .wdata    (reg_wdata[28:0]),
        .sh_done  (sh_done),
        .sh_rdata (sh_rdata),
        .busy     (busy),
        .rvalid   (rvalid),
        .cmd_q    (cmd_q),
        .addr_q   (addr_q),
        .sh_start (sh_start),
        .sh_frame (sh_frame),
        .sh_rd    (sh_rd)
    );

    xmdio_shifter u_shf (
        .clk     (clk),
        .rst     (rst),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk),
        .start   (sh_start),
        .frame   (sh_frame),
        .rd_mode (sh_rd),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (sh_done),
        .rdata   (sh_rdata)
    );

    always_comb begin
        if (sel_cmd) begin
            reg_rdata = {1'b0, busy, rvalid, cmd_q.code, cmd_q.dev,
                         cmd_q.port, cmd_q.data};
        end else if (sel_adr) begin
            reg_rdata = {16'h0000, addr_q};
        end else begin
            reg_rdata = '0;
        end
    end
endmodule

// File: rtl/xmdio_master_chk.sv
module xmdio_master_chk
    import xmdio_pkg::*;
#(
    parameter int OFS_W   = 4,
    parameter int OFS_CMD = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [OFS_W-1:0] reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             busy,
    input logic             rvalid,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic [4:0]       cur_port,
    input logic [4:0]       cur_dev
);
    logic cmd_wr;
    assign cmd_wr = reg_wr && (reg_addr == OFS_W'(OFS_CMD));

    p_accept_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && code_ok(reg_wdata[CODE_LSB +: 3])) |=> busy);

    p_badcode_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && !code_ok(reg_wdata[CODE_LSB +: 3])) |=> !busy);

    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy) |=> ($stable(cur_port) && $stable(cur_dev)));

    p_rvalid_idle_r9: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> !busy);

    p_rvalid_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !rvalid);

    p_oe_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    p_mdio_edge_r10: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));
endmodule

bind xmdio_master xmdio_master_chk #(.OFS_W(OFS_W), .OFS_CMD(OFS_CMD)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .rvalid    (rvalid),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .cur_port  (cmd_q.port),
    .cur_dev   (cmd_q.dev)
);

// File: tb/xmdio_master_test.sv
module xmdio_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_HALF   = 2;
    localparam int OFS_W      = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [OFS_W-1:0] reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // bus model state
    logic        phy_drv = 1'b0;
    logic        phy_bit = 1'b1;
    logic [15:0] phy_mem [8];
    logic [15:0] phy_addr = '0;
    logic [15:0] rd_word = '0;
    logic        coll = 1'b0;
    logic        is_rd = 1'b0;
    int          ones = 0;
    int          drv_ones = 0;
    int          bcnt = 0;
    logic [31:0] sh = '0;
    int          nfr = 0;
    logic [31:0] fr_bits [8];
    int          fr_pre [8];
    logic        drove_late = 1'b0;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

    xmdio_master #(.DIV_HALF(DIV_HALF), .OFS_W(OFS_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        for (int i = 0; i < 8; i++) phy_mem[i] = 16'hA500 + 16'(i);
    end

    always @(posedge mdc) begin
        if (rst) begin
            coll = 1'b0; ones = 0; drv_ones = 0; bcnt = 0;
        end else if (!coll) begin
            if (mdio_i) begin
                ones = ones + 1;
                drv_ones = mdio_oe ? drv_ones + 1 : 0;
            end else begin
                if (ones >= 32) begin
                    coll = 1'b1; bcnt = 1; sh = 32'h0;
                end
                ones = 0;
            end
        end else begin
            if (is_rd && bcnt >= 14 && mdio_oe) drove_late = 1'b1;
            sh = {sh[30:0], mdio_i};
            bcnt = bcnt + 1;
            if (bcnt == 4) begin
                is_rd = (sh[1:0] == 2'b11);
                rd_word = phy_mem[phy_addr[2:0]];
            end
            if (bcnt == 32) begin
                fr_bits[nfr % 8] = sh;
                fr_pre[nfr % 8]  = drv_ones;
                if (sh[29:28] == 2'b00) phy_addr = sh[15:0];
                if (sh[29:28] == 2'b01) phy_mem[phy_addr[2:0]] = sh[15:0];
                nfr = nfr + 1;
                coll = 1'b0; is_rd = 1'b0; drv_ones = 0; bcnt = 0;
            end
        end
    end

    always @(negedge mdc) begin
        if (coll && is_rd && bcnt >= 15 && bcnt <= 31) begin
            phy_drv = 1'b1;
            phy_bit = (bcnt == 15) ? 1'b0 : rd_word[31 - bcnt];
        end else begin
            phy_drv = 1'b0;
            phy_bit = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [OFS_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [OFS_W-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cmd(input logic [2:0] c, input logic [4:0] p,
                                        input logic [4:0] dv, input logic [15:0] d);
        return {3'b000, c, dv, p, d};
    endfunction

    // waits for idle; busy must not drop before the expected frame count
    task automatic wait_idle(input int exp_frames, input string tag);
        logic [31:0] v;
        int n = 0;
        rd(4'h0, v);
        while (v[30] && n < 5000) begin
            @(negedge clk);
            rd(4'h0, v);
            n++;
        end
        chk(n < 5000, {tag, " timeout"}, 32'(n), 32'd5000);
        chk(nfr == exp_frames, {tag, " R7 busy held until frames done"},
            32'(nfr), 32'(exp_frames));
        chk(mdio_oe == 1'b0, {tag, " R11 oe idle"}, {31'b0, mdio_oe}, 32'h0);
    endtask

    task automatic check_frame(input int idx, input logic [1:0] op, input logic [4:0] p,
                               input logic [4:0] dv, input logic [1:0] ta,
                               input logic [15:0] d, input string tag);
        logic [31:0] f;
        f = fr_bits[idx % 8];
        chk(f == {2'b00, op, p, dv, ta, d}, tag, f, {2'b00, op, p, dv, ta, d});
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        rd(4'h0, v); chk(v == 32'h0, "R1 cmd reg reset", v, 32'h0);
        rd(4'h8, v); chk(v == 32'h0, "R1 addr reg reset", v, 32'h0);
        chk(mdio_oe == 1'b0, "R1 oe reset", {31'b0, mdio_oe}, 32'h0);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        wr(4'h8, 32'hABCD_0005);
        rd(4'h8, v); chk(v == 32'h0000_0005, "R2 addr reg readback", v, 32'h5);
        rd(4'h4, v); chk(v == 32'h0, "R2 unmapped offset", v, 32'h0);
    endtask

    task automatic t_mdc;
        int t0, t1;
        @(posedge mdc); t0 = cyc;
        @(posedge mdc); t1 = cyc;
        chk((t1 - t0) == 2 * DIV_HALF, "R10 mdc period", 32'(t1 - t0), 32'(2 * DIV_HALF));
    endtask

    task automatic t_write;
        logic [31:0] v;
        int base = nfr;
        wr(4'h0, cmd(3'b101, 5'd3, 5'd1, 16'hBEEF));
        rd(4'h0, v); chk(v[30] == 1'b1, "R3 busy after write cmd", v, 32'h4000_0000);
        wait_idle(base + 2, "write");
        check_frame(base, 2'b00, 5'd3, 5'd1, 2'b10, 16'h0005, "R4 address frame");
        chk(fr_pre[base % 8] == 32, "R4 preamble ones", 32'(fr_pre[base % 8]), 32'd32);
        check_frame(base + 1, 2'b01, 5'd3, 5'd1, 2'b10, 16'hBEEF, "R5 write frame");
        chk(fr_pre[(base + 1) % 8] == 32, "R4 preamble data frame",
            32'(fr_pre[(base + 1) % 8]), 32'd32);
        rd(4'h0, v);
        chk(v == {3'b000, 3'b101, 5'd1, 5'd3, 16'hBEEF}, "R2 R9 cmd readback after write",
            v, {3'b000, 3'b101, 5'd1, 5'd3, 16'hBEEF});
    endtask

    task automatic t_read(input logic [15:0] a, input logic [4:0] p, input logic [4:0] dv,
                          input logic [15:0] exp, input string tag);
        logic [31:0] v;
        int base = nfr;
        drove_late = 1'b0;
        wr(4'h8, {16'h0, a});
        wr(4'h0, cmd(3'b111, p, dv, 16'h0000));
        rd(4'h0, v); chk(v[29] == 1'b0 && v[30], {tag, " R9 rvalid cleared on start"},
                         v & 32'h6000_0000, 32'h4000_0000);
        wait_idle(base + 2, tag);
        check_frame(base, 2'b00, p, dv, 2'b10, a, {tag, " R4 address frame"});
        check_frame(base + 1, 2'b11, p, dv, 2'b10, exp, {tag, " R6 read frame on wire"});
        chk(!drove_late, {tag, " R6 master released line"}, {31'b0, drove_late}, 32'h0);
        rd(4'h0, v);
        chk(v[29] && v[15:0] == exp, {tag, " R6 read data valid"}, v & 32'h2000_FFFF,
            {16'h2000, exp});
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v;
        int base = nfr;
        wr(4'h8, 32'h0000_0003);
        wr(4'h0, cmd(3'b101, 5'd7, 5'd4, 16'h1357));
        wr(4'h0, cmd(3'b111, 5'd9, 5'd2, 16'h0000));
        wr(4'h8, 32'h0000_0006);
        rd(4'h0, v);
        chk(v[20:16] == 5'd7 && v[25:21] == 5'd4, "R8 fields kept while busy",
            {22'b0, v[25:16]}, {22'b0, 5'd4, 5'd7});
        wait_idle(base + 2, "ignore R8");
        check_frame(base, 2'b00, 5'd7, 5'd4, 2'b10, 16'h0003, "R4 address captured at accept");
        check_frame(base + 1, 2'b01, 5'd7, 5'd4, 2'b10, 16'h1357, "R8 only original op sent");
        repeat (300) @(negedge clk);
        chk(nfr == base + 2, "R8 no extra frames", 32'(nfr), 32'(base + 2));
    endtask

    task automatic t_badcode;
        logic [31:0] v;
        int base = nfr;
        wr(4'h0, cmd(3'b010, 5'd1, 5'd1, 16'h1111));
        rd(4'h0, v); chk(v[30] == 1'b0, "R3 bad code no busy", v, 32'h0);
        repeat (300) @(negedge clk);
        chk(nfr == base, "R3 bad code no frames", 32'(nfr), 32'(base));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_mdc();
        t_write();
        t_read(16'h0005, 5'd3, 5'd1, 16'hBEEF, "read1");
        t_read(16'h0002, 5'd12, 5'd30, 16'hA502, "read2");
        t_busy_ignore();
        t_read(16'h0003, 5'd0, 5'd31, 16'h1357, "read3");
        t_badcode();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule